// File: doc/BRIEF.md
# Task-Driven Full-Duplex Serial Transceiver

This block is an asynchronous serial transceiver controlled by one-cycle task strobes rather than by polled status. Separate strobes start and stop the receiver and the transmitter. The block reports progress with one-cycle event pulses: a received byte was stored, a transmitted frame completed, and the receiver has come to rest after a stop request. Transmit and receive work at the same time and independently. Each uses its own bit timer, derived from a programmable clock divisor, with 16 timer ticks per bit.

Transmit bytes enter through a valid/ready port. A byte transfers on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` is high only while the transmitter is started, idle and, when flow control is on, permitted by CTS. The source may hold `tx_valid` high with stable data for as long as needed. Received bytes leave through a second valid/ready port fed by a six-entry buffer. `rx_valid` stays high while the buffer holds data, and a byte is removed on each edge where `rx_ready` is also high.

Optional even parity adds a ninth bit after the data bits. Optional hardware flow control uses active-low RTS and CTS. Each line can be marked unconnected. An unconnected input then reads as its inactive (high) level, and an unconnected output has its output enable low.

Top module: `serial_link`

## Requirements
- R1: A transmitted frame has one low start bit, then eight data bits LSB first, then exactly one high stop bit. Each bit lasts 16 × `cfg_divisor` clocks. `txd_o` is high whenever no frame is being sent. Transmit and receive operate concurrently.
- R2: With `cfg_parity_en` high, a ninth bit is sent between the data and the stop bit. Its value makes the number of ones across data and parity even.
- R3: The receiver rebuilds bytes from `rxd_i` LSB first and stores each byte in the buffer. With parity on, a parity mismatch sets `err_parity` and the byte is still stored.
- R4: A stop bit sampled low sets `err_frame` and the byte is still stored. A receive-start task clears `err_parity`, `err_frame` and `err_overrun`.
- R5: A start bit is accepted only if the line is still low at the middle of the bit. A low pulse shorter than half a bit stores nothing.
- R6: The receive buffer holds six bytes and returns them oldest first over the rx valid/ready port. A byte that arrives while six are held is discarded and sets `err_overrun`.
- R7: `ev_rx_ready` pulses once for each stored byte. `ev_tx_done` pulses once for each completed transmit frame.
- R8: The transmitter accepts bytes only after a transmit-start task and before a transmit-stop task. A stop task given during a frame lets that frame finish in full and prevents any further frame.
- R9: After a receive-stop task, a frame already in progress completes and is stored. `ev_rx_timeout` then pulses once and no further frame is received.
- R10: With `cfg_flow_en` high, `tx_ready` is low and no frame starts while the effective CTS is high.
- R11: With `cfg_flow_en` high, `rts_n_o` is low only while the receiver is started and the buffer has room for more than four further bytes (at most one byte held). Otherwise `rts_n_o` is high. It is also high when flow control is off.
- R12: An unconnected RXD ignores `rxd_i` (the line reads high). An unconnected CTS reads high. An unconnected TXD or RTS output has its output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_divisor | input | 16 | Clocks per oversample tick (bit = 16 ticks) |
| cfg_parity_en | input | 1 | Even parity as ninth bit |
| cfg_flow_en | input | 1 | RTS/CTS flow control |
| cfg_rxd_conn | input | 1 | RXD line connected |
| cfg_cts_conn | input | 1 | CTS line connected |
| cfg_txd_conn | input | 1 | TXD line connected |
| cfg_rts_conn | input | 1 | RTS line connected |
| task_rx_start | input | 1 | Start-receive strobe |
| task_rx_stop | input | 1 | Stop-receive strobe |
| task_tx_start | input | 1 | Start-transmit strobe |
| task_tx_stop | input | 1 | Stop-transmit strobe |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_valid | output | 1 | Buffer holds a byte |
| rx_data | output | 8 | Oldest buffered byte |
| rx_ready | input | 1 | Consumer takes the byte |
| ev_rx_ready | output | 1 | Byte stored event |
| ev_tx_done | output | 1 | Frame sent event |
| ev_rx_timeout | output | 1 | Receiver halted event |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| rxd_i | input | 1 | Serial input |
| cts_n_i | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial output |
| txd_oe | output | 1 | TXD output enable |
| rts_n_o | output | 1 | Request to send, active low |
| rts_n_oe | output | 1 | RTS output enable |

## Verification
Transmit frames are decoded at mid-bit for several bytes, with and without parity. Odd and even one-counts show whether the parity bit is computed or just constant. Receive frames use good parity, bad parity, a low stop bit and a short glitch, which separates storing from flagging from rejecting. A burst of seven frames with no reads tells buffer depth and ordering apart from overrun. Simultaneous transmit and receive, together with stop tasks issued in the middle of a frame, show that the two directions are independent and that frames complete before stopping.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int OVS   = 16;
  localparam int DBITS = 8;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
endpackage

// File: rtl/slk_tick.sv
module slk_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && !restart && (({1'b0, cnt} + 1'b1) >= {1'b0, div});

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !en) cnt <= '0;
    else if (tick)                cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slk_tx.sv
module slk_tx
  import slk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             task_start,
  input  logic             task_stop,
  input  logic             parity_en,
  input  logic             flow_en,
  input  logic             cts_n,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             ser,
  output logic             done
);
  logic        active, busy, tick, load;
  logic [10:0] sh;
  logic [3:0]  ocnt, bitn, last;

  assign last     = parity_en ? 4'd10 : 4'd9;
  assign tx_ready = en && active && !busy && (!flow_en || !cts_n);
  assign load     = tx_valid && tx_ready;
  assign done     = busy && tick && (ocnt == 4'(OVS-1)) && (bitn == last);
  assign ser      = busy ? sh[0] : 1'b1;

  slk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en && busy), .restart(load), .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  active <= 1'b0;
    else if (task_stop) active <= 1'b0;
    else if (task_start) active <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy <= 1'b0; sh <= '1; ocnt <= '0; bitn <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sh   <= {1'b1, (parity_en ? ^tx_data : 1'b1), tx_data, 1'b0};
      ocnt <= '0; bitn <= '0;
    end else if (busy && tick) begin
      if (ocnt == 4'(OVS-1)) begin
        ocnt <= '0;
        if (done) busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[10:1]};
          bitn <= bitn + 1'b1;
        end
      end else ocnt <= ocnt + 1'b1;
    end
  end

  a_r10_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && cts_n) |-> !tx_ready);
  a_r1_done_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ser);
  a_r8_frame_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && en) |=> busy);
endmodule

// File: rtl/slk_rxbuf.sv
module slk_rxbuf #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          acc, tak;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign acc   = push && !full;
  assign tak   = pop && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (acc) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (tak) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(acc) - CW'(tak);
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= wdata;
  end

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wp)));
endmodule

// File: rtl/slk_rx.sv
module slk_rx
  import slk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             task_start,
  input  logic             task_stop,
  input  logic             parity_en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  input  logic             buf_full,
  output logic             push,
  output logic [7:0]       rbyte,
  output logic             active,
  output logic             ev_timeout,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun
);
  rx_state_t  st;
  logic       r1, r2, r3, tick, start_det, sample, at_stop, pend, par_bit;
  logic [3:0] ocnt, bitn, last;
  logic [7:0] sh;

  assign last      = parity_en ? 4'd9 : 4'd8;
  assign start_det = (st == RX_IDLE) && active && r3 && !r2;
  assign sample    = (st == RX_BITS) && tick && (ocnt == 4'(OVS-1));
  assign at_stop   = sample && (bitn == last);
  assign push      = at_stop && !buf_full;
  assign rbyte     = sh;

  slk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en && (st != RX_IDLE)), .restart(start_det),
    .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin r1 <= 1'b1; r2 <= 1'b1; r3 <= 1'b1; end
    else        begin r1 <= rxd;  r2 <= r1;   r3 <= r2;   end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      active <= 1'b0; pend <= 1'b0; ev_timeout <= 1'b0;
    end else begin
      if (task_stop) active <= 1'b0;
      else if (task_start) active <= 1'b1;
      ev_timeout <= pend && (st == RX_IDLE);
      if (task_stop && active) pend <= 1'b1;
      else if (st == RX_IDLE)  pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_frame <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
    end else if (task_start) begin
      err_frame <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
    end else if (at_stop) begin
      if (!r2)      err_frame   <= 1'b1;
      if (buf_full) err_overrun <= 1'b1;
      if (parity_en && ((^sh) != par_bit)) err_parity <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st <= RX_IDLE; ocnt <= '0; bitn <= '0; sh <= '0; par_bit <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: if (start_det) begin st <= RX_START; ocnt <= '0; end
        RX_START: if (tick) begin
          if (ocnt == 4'(OVS/2-1)) begin
            ocnt <= '0; bitn <= '0;
            st   <= r2 ? RX_IDLE : RX_BITS;
          end else ocnt <= ocnt + 1'b1;
        end
        RX_BITS: if (tick) begin
          if (ocnt == 4'(OVS-1)) begin
            ocnt <= '0;
            if (bitn < 4'(DBITS)) sh <= {r2, sh[7:1]};
            if (bitn == 4'(DBITS) && parity_en) par_bit <= r2;
            if (bitn == last) st <= RX_IDLE;
            else bitn <= bitn + 1'b1;
          end else ocnt <= ocnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  a_r9_timeout_halted: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> (!active && st == RX_IDLE));
  a_r3_push_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (st == RX_IDLE));
endmodule

// File: rtl/serial_link.sv
module serial_link #(
  parameter int DIV_W    = 16,
  parameter int RX_DEPTH = 6,
  parameter int RTS_ROOM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_parity_en,
  input  logic             cfg_flow_en,
  input  logic             cfg_rxd_conn,
  input  logic             cfg_cts_conn,
  input  logic             cfg_txd_conn,
  input  logic             cfg_rts_conn,
  input  logic             task_rx_start,
  input  logic             task_rx_stop,
  input  logic             task_tx_start,
  input  logic             task_tx_stop,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             ev_rx_ready,
  output logic             ev_tx_done,
  output logic             ev_rx_timeout,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun,
  input  logic             rxd_i,
  input  logic             cts_n_i,
  output logic             txd_o,
  output logic             txd_oe,
  output logic             rts_n_o,
  output logic             rts_n_oe
);
  localparam int CW = $clog2(RX_DEPTH+1);

  logic          rxd_eff, cts_eff, ser, rx_active, push, buf_full, buf_empty;
  logic [7:0]    rbyte;
  logic [CW-1:0] buf_cnt;

  assign rxd_eff = cfg_rxd_conn ? rxd_i   : 1'b1;
  assign cts_eff = cfg_cts_conn ? cts_n_i : 1'b1;

  slk_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .task_start(task_tx_start),
    .task_stop(task_tx_stop), .parity_en(cfg_parity_en), .flow_en(cfg_flow_en),
    .cts_n(cts_eff), .div(cfg_divisor), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ser(ser), .done(ev_tx_done)
  );

  slk_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .task_start(task_rx_start),
    .task_stop(task_rx_stop), .parity_en(cfg_parity_en), .rxd(rxd_eff),
    .div(cfg_divisor), .buf_full(buf_full), .push(push), .rbyte(rbyte),
    .active(rx_active), .ev_timeout(ev_rx_timeout), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  slk_rxbuf #(.DEPTH(RX_DEPTH), .W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(rbyte), .pop(rx_ready),
    .rdata(rx_data), .cnt(buf_cnt), .full(buf_full), .empty(buf_empty)
  );

  assign rx_valid    = !buf_empty;
  assign ev_rx_ready = push;
  assign txd_oe      = cfg_enable && cfg_txd_conn;
  assign rts_n_oe    = cfg_enable && cfg_rts_conn;
  assign txd_o       = txd_oe ? ser : 1'b1;
  assign rts_n_o     = !(cfg_flow_en && rx_active &&
                         ((RX_DEPTH - int'(buf_cnt)) > RTS_ROOM));

  a_r11_rts_headroom: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(buf_cnt) + RTS_ROOM) >= RX_DEPTH) |-> rts_n_o);
  a_r7_event_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ready && !(rx_valid && rx_ready)) |=> rx_valid);
endmodule

// File: tb/serial_link_tb.sv
module serial_link_tb_top;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_parity_en = 1'b0, cfg_flow_en = 1'b0;
  logic [15:0] cfg_divisor = 16'(DIV);
  logic cfg_rxd_conn = 1'b1, cfg_cts_conn = 1'b1, cfg_txd_conn = 1'b1, cfg_rts_conn = 1'b1;
  logic task_rx_start = 1'b0, task_rx_stop = 1'b0, task_tx_start = 1'b0, task_tx_stop = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, rxd_i = 1'b1, cts_n_i = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, ev_rx_ready, ev_tx_done, ev_rx_timeout;
  logic err_parity, err_frame, err_overrun, txd_o, txd_oe, rts_n_o, rts_n_oe;
  logic [7:0] rx_data;

  int nchk = 0, nerr = 0, n_rxev = 0, n_txev = 0, n_toev = 0;

  always #4 clk = ~clk;

  serial_link dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_divisor(cfg_divisor),
    .cfg_parity_en(cfg_parity_en), .cfg_flow_en(cfg_flow_en),
    .cfg_rxd_conn(cfg_rxd_conn), .cfg_cts_conn(cfg_cts_conn),
    .cfg_txd_conn(cfg_txd_conn), .cfg_rts_conn(cfg_rts_conn),
    .task_rx_start(task_rx_start), .task_rx_stop(task_rx_stop),
    .task_tx_start(task_tx_start), .task_tx_stop(task_tx_stop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ev_rx_ready(ev_rx_ready), .ev_tx_done(ev_tx_done), .ev_rx_timeout(ev_rx_timeout),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .rxd_i(rxd_i), .cts_n_i(cts_n_i), .txd_o(txd_o), .txd_oe(txd_oe),
    .rts_n_o(rts_n_o), .rts_n_oe(rts_n_oe)
  );

  always @(posedge clk) begin
    if (ev_rx_ready)   n_rxev <= n_rxev + 1;
    if (ev_tx_done)    n_txev <= n_txev + 1;
    if (ev_rx_timeout) n_toev <= n_toev + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 no parity bit, 1 correct even parity, 2 wrong parity
  task automatic drive_rx(input logic [7:0] d, input int mode, input logic stopb);
    @(negedge clk); rxd_i = 1'b0; wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; wait_clk(BIT); end
    if (mode != 0) begin rxd_i = (^d) ^ (mode == 2); wait_clk(BIT); end
    rxd_i = stopb; wait_clk(BIT);
    rxd_i = 1'b1; wait_clk(4);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic grab(input string req, input logic [7:0] exp, input logic par);
    logic [7:0] d;
    int guard = 0;
    @(negedge clk);
    while (txd_o && guard < 4000) begin @(negedge clk); guard++; end
    wait_clk(BIT/2);
    check({req, " start low"}, int'(txd_o), 0);
    for (int i = 0; i < 8; i++) begin wait_clk(BIT); d[i] = txd_o; end
    check({req, " data"}, int'(d), int'(exp));
    if (par) begin wait_clk(BIT); check("R2 parity bit", int'(txd_o), int'(^exp)); end
    wait_clk(BIT);
    check({req, " stop high"}, int'(txd_o), 1);
    wait_clk(BIT/2 + 2);
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    check({req, " valid"}, int'(rx_valid), 1);
    check({req, " data"}, int'(rx_data), int'(exp));
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 idle txd high", int'(txd_o), 1);
    check("R11 rts high after reset", int'(rts_n_o), 1);
    check("R6 buffer empty", int'(rx_valid), 0);
    check("R8 tx not ready before start", int'(tx_ready), 0);
  endtask

  task automatic t_tx_basic;
    int e0 = n_txev;
    pulse(task_tx_start);
    fork send(8'hA5); grab("R1", 8'hA5, 1'b0); join
    check("R7 tx done event", n_txev - e0, 1);
    fork send(8'h3C); grab("R1 second", 8'h3C, 1'b0); join
  endtask

  task automatic t_tx_parity;
    cfg_parity_en = 1'b1;
    fork send(8'h07); grab("R2 odd ones", 8'h07, 1'b1); join
    fork send(8'h03); grab("R2 even ones", 8'h03, 1'b1); join
    cfg_parity_en = 1'b0;
  endtask

  task automatic t_rx_basic;
    int e0;
    pulse(task_rx_start);
    e0 = n_rxev;
    drive_rx(8'h3C, 0, 1'b1);
    check("R7 rx event", n_rxev - e0, 1);
    pop_check("R3 rx byte", 8'h3C);
  endtask

  task automatic t_rx_parity;
    cfg_parity_en = 1'b1;
    drive_rx(8'h5A, 1, 1'b1);
    check("R3 good parity no flag", int'(err_parity), 0);
    drive_rx(8'h5B, 2, 1'b1);
    check("R3 bad parity flagged", int'(err_parity), 1);
    pop_check("R3 good parity byte", 8'h5A);
    pop_check("R3 bad parity byte kept", 8'h5B);
    cfg_parity_en = 1'b0;
  endtask

  task automatic t_frame;
    pulse(task_rx_start);
    drive_rx(8'h81, 0, 1'b0);
    wait_clk(BIT);
    check("R4 framing flag", int'(err_frame), 1);
    pop_check("R4 byte kept", 8'h81);
    pulse(task_rx_start);
    @(negedge clk);
    check("R4 flags cleared by start", int'({err_frame, err_parity, err_overrun}), 0);
  endtask

  task automatic t_glitch;
    int e0 = n_rxev;
    @(negedge clk); rxd_i = 1'b0; wait_clk(BIT/4); rxd_i = 1'b1;
    wait_clk(2*BIT);
    check("R5 glitch stores nothing", n_rxev - e0, 0);
    check("R5 buffer still empty", int'(rx_valid), 0);
  endtask

  task automatic t_fifo;
    int e0 = n_rxev;
    for (int i = 0; i < 7; i++) drive_rx(8'(8'h10 + i), 0, 1'b1);
    check("R6 six stored events", n_rxev - e0, 6);
    check("R6 overrun flag", int'(err_overrun), 1);
    for (int i = 0; i < 6; i++) pop_check("R6 order", 8'(8'h10 + i));
    @(negedge clk);
    check("R6 seventh dropped", int'(rx_valid), 0);
    pulse(task_rx_start);
  endtask

  task automatic t_rts;
    cfg_flow_en = 1'b1;
    @(negedge clk);
    check("R11 rts low empty", int'(rts_n_o), 0);
    drive_rx(8'h01, 0, 1'b1);
    check("R11 rts low one held", int'(rts_n_o), 0);
    drive_rx(8'h02, 0, 1'b1);
    check("R11 rts high two held", int'(rts_n_o), 1);
    pop_check("R11 pop", 8'h01);
    check("R11 rts low again", int'(rts_n_o), 0);
    pop_check("R11 pop2", 8'h02);
    cfg_flow_en = 1'b0;
  endtask

  task automatic t_cts;
    int bad = 0;
    cfg_flow_en = 1'b1; cts_n_i = 1'b1;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h6E;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_ready || !txd_o) bad++;
    end
    check("R10 blocked while cts high", bad, 0);
    tx_valid = 1'b0;
    cts_n_i = 1'b0;
    fork send(8'h6E); grab("R10 after cts low", 8'h6E, 1'b0); join
    cfg_flow_en = 1'b0;
  endtask

  task automatic t_duplex;
    int e0 = n_rxev;
    fork
      send(8'hC3);
      grab("R1 duplex tx", 8'hC3, 1'b0);
      drive_rx(8'h96, 0, 1'b1);
    join
    check("R1 duplex rx event", n_rxev - e0, 1);
    pop_check("R1 duplex rx", 8'h96);
  endtask

  task automatic t_tx_stop;
    int bad = 0;
    int e0 = n_txev;
    fork
      send(8'h4D);
      grab("R8 stop mid-frame", 8'h4D, 1'b0);
      begin wait_clk(3*BIT); pulse(task_tx_stop); end
    join
    check("R8 frame completed", n_txev - e0, 1);
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h11;
    for (int i = 0; i < 2*BIT; i++) begin
      @(negedge clk);
      if (tx_ready || !txd_o) bad++;
    end
    tx_valid = 1'b0;
    check("R8 no frame after stop", bad, 0);
  endtask

  task automatic t_rx_stop;
    int e0 = n_rxev;
    int t0 = n_toev;
    fork
      drive_rx(8'h99, 0, 1'b1);
      begin
        wait_clk(3*BIT); pulse(task_rx_stop); wait_clk(4);
        check("R9 no timeout mid-frame", n_toev - t0, 0);
      end
    join
    check("R9 in-flight byte stored", n_rxev - e0, 1);
    check("R9 timeout event", n_toev - t0, 1);
    pop_check("R9 byte", 8'h99);
    drive_rx(8'h77, 0, 1'b1);
    check("R9 nothing after stop", n_rxev - e0, 1);
  endtask

  task automatic t_unconn;
    int e0;
    pulse(task_rx_start);
    cfg_rxd_conn = 1'b0;
    e0 = n_rxev;
    drive_rx(8'h00, 0, 1'b0);
    check("R12 rxd ignored", n_rxev - e0, 0);
    cfg_rxd_conn = 1'b1;
    cfg_txd_conn = 1'b0; cfg_rts_conn = 1'b0;
    @(negedge clk);
    check("R12 txd not driven", int'(txd_oe), 0);
    check("R12 rts not driven", int'(rts_n_oe), 0);
    cfg_txd_conn = 1'b1; cfg_rts_conn = 1'b1;
    pulse(task_tx_start);
    cfg_flow_en = 1'b1; cfg_cts_conn = 1'b0; cts_n_i = 1'b0;
    @(negedge clk);
    check("R12 cts reads inactive", int'(tx_ready), 0);
    cfg_flow_en = 1'b0; cfg_cts_conn = 1'b1;
  endtask

  initial begin
    wait_clk(3);
    cfg_enable = 1'b1;
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_tx_basic();
    t_tx_parity();
    t_rx_basic();
    t_rx_parity();
    t_frame();
    t_glitch();
    t_fifo();
    t_rts();
    t_cts();
    t_duplex();
    t_tx_stop();
    t_rx_stop();
    t_unconn();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule